// File: doc/BRIEF.md
# Minimal Harvard Processor Core

A compact single-issue processor whose instruction and data traffic travel on two separate buses. The instruction side is a read-only port: the core presents a fetch address and expects the 16-bit instruction word back in the same cycle. The data side is a read/write port used only by load and store instructions. Inside the core sit a program counter, an instruction register, a sixteen-entry register file whose top entry is an alias of the program counter, a four-flag status register, a combinational ALU and a control decoder that steers the ALU, register writeback and branching.

Each instruction takes two clock cycles. In the fetch cycle the word at the program counter is captured and the counter steps by one. In the execute cycle the decoder acts on the captured word. An embedding system attaches an instruction store with a combinational read and a data store that accepts writes on the clock edge. A short counted loop built from compare and jump-on-zero instructions is the typical workload.

Top module: `harv_core`

## Requirements
- R1: While rst_n is low the program counter, instruction register and all four flags are cleared, imem_addr reads 0, and dmem_we and dmem_re are 0; the first fetch after release is from address 0.
- R2: Instructions alternate a fetch cycle (the word on imem_rdata is captured and imem_addr steps by one) and an execute cycle; with no jump, consecutive fetch addresses differ by one.
- R3: Instruction word layout is opcode [15:12], destination/condition [11:8], source [7:4], 8-bit immediate or target [7:0]; opcode 8 loads the program counter with bits [7:0], and a taken opcode 9 does the same, replacing the increment.
- R4: The register file has sixteen entries; 0 to 14 are ordinary storage (13 conventionally stack pointer, 14 link), a read of entry 15 returns the address of the instruction after the one executing, and a write to entry 15 loads the program counter with the low bits of the written value.
- R5: Data accesses happen only in an execute cycle, on their own address, write-data and strobe pins, while imem_addr already carries the next fetch address; dmem_we and dmem_re are never high together.
- R6: Opcode 1 (rd = rd + rs) and opcode 2 (rd = rd - rs) update all flags: N is the result's top bit, Z is set for an all-zero result, C is the carry out of an addition or 1 when a subtraction needs no borrow, V is set on signed overflow.
- R7: Opcodes 3 (AND), 4 (OR) and 5 (XOR) write rd op rs to rd, update N and Z, and leave C and V unchanged.
- R8: Opcode 7 compares rd with the zero-extended immediate [7:0] as a subtraction, sets the flags as in R6 (Z set exactly when equal) and writes no register.
- R9: Opcode 9 tests the flag chosen by bits [11:8]: 0 selects Z, 1 selects N, 2 selects C, 3 selects V, any other value never jumps; when the test fails execution continues at the next address.
- R10: Opcode 10 loads rd from the data word at address rs; opcode 11 drives address rs, write data rd and a one-cycle dmem_we.
- R11: Opcode 0 writes the zero-extended immediate [7:0] to rd and opcode 6 copies rs to rd; neither changes the flags, and opcodes 12 to 15 do nothing.
- R12: A counted loop that doubles register 0 ten times from 1 leaves 1024 in register 0 and 0 in the loop counter, as seen through stores.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PC_W | Instruction fetch address |
| imem_rdata | input | 16 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | DADDR_W | Data access address |
| dmem_wdata | output | DATA_W | Data to be written |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_rdata | input | DATA_W | Data word at dmem_addr, same cycle |

## Verification
Two programs are run against a behavioural model that tracks fetch address and every data-port transaction each cycle. The counted loop separates a correct compare-then-jump-on-zero from an off-by-one or a missing Z update, since either changes both the fetch trace and the stored results. The second program reaches an overflow, a carry-producing wrap to zero, logic operations and a register-15 read and write, and its branch choices depend on N, C, V and Z in turn, so a flag computed wrongly or a condition code wired to the wrong flag sends the fetch trace down a different path. A reset asserted mid-program checks that the counter returns to 0.

// File: rtl/harv_pkg.sv
package harv_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int REG_AW  = 4;
  localparam int NREG    = 1 << REG_AW;

  typedef enum logic [OPC_W-1:0] {
    OP_MOVI = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_ORR  = 4'd4,
    OP_EOR  = 4'd5,
    OP_MOV  = 4'd6,
    OP_CMPI = 4'd7,
    OP_JMP  = 4'd8,
    OP_JCC  = 4'd9,
    OP_LD   = 4'd10,
    OP_ST   = 4'd11
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_ORR,
    ALU_EOR,
    ALU_PASS
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU,
    WB_IMM,
    WB_MEM
  } wb_sel_e;

  typedef enum logic {
    PH_FETCH,
    PH_EXEC
  } phase_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    alu_op_e alu_op;
    logic    b_imm;
    logic    set_nz;
    logic    set_cv;
    logic    mem_wr;
    logic    mem_rd;
  } ctrl_t;

endpackage

// File: rtl/harv_alu.sv
module harv_alu
  import harv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output flags_t       flags
);

  logic [W:0] wide;

  always_comb begin
    wide    = '0;
    y       = '0;
    flags.c = 1'b0;
    flags.v = 1'b0;
    unique case (op)
      ALU_ADD: begin
        wide    = {1'b0, a} + {1'b0, b};
        y       = wide[W-1:0];
        flags.c = wide[W];
        flags.v = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
      end
      ALU_SUB: begin
        wide    = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        y       = wide[W-1:0];
        flags.c = wide[W];
        flags.v = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
      end
      ALU_AND:  y = a & b;
      ALU_ORR:  y = a | b;
      ALU_EOR:  y = a ^ b;
      ALU_PASS: y = b;
      default:  y = '0;
    endcase
    flags.n = y[W-1];
    flags.z = (y == '0);
  end

endmodule

// File: rtl/harv_decode.sv
module harv_decode
  import harv_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [REG_AW-1:0] cond,
  input  flags_t            flags,
  output ctrl_t             ctrl,
  output logic              take
);

  logic cond_ok;

  always_comb begin
    unique case (cond)
      4'd0:    cond_ok = flags.z;
      4'd1:    cond_ok = flags.n;
      4'd2:    cond_ok = flags.c;
      4'd3:    cond_ok = flags.v;
      default: cond_ok = 1'b0;
    endcase
  end

  always_comb begin
    ctrl        = '0;
    ctrl.wb_sel = WB_ALU;
    ctrl.alu_op = ALU_PASS;
    take        = 1'b0;
    unique case (opcode_e'(opcode))
      OP_MOVI: begin
        ctrl.rf_we  = 1'b1;
        ctrl.wb_sel = WB_IMM;
      end
      OP_ADD, OP_SUB: begin
        ctrl.rf_we  = 1'b1;
        ctrl.alu_op = (opcode_e'(opcode) == OP_ADD) ? ALU_ADD : ALU_SUB;
        ctrl.set_nz = 1'b1;
        ctrl.set_cv = 1'b1;
      end
      OP_AND, OP_ORR, OP_EOR: begin
        ctrl.rf_we  = 1'b1;
        ctrl.set_nz = 1'b1;
        ctrl.alu_op = (opcode_e'(opcode) == OP_AND) ? ALU_AND :
                      (opcode_e'(opcode) == OP_ORR) ? ALU_ORR : ALU_EOR;
      end
      OP_MOV: ctrl.rf_we = 1'b1;
      OP_CMPI: begin
        ctrl.alu_op = ALU_SUB;
        ctrl.b_imm  = 1'b1;
        ctrl.set_nz = 1'b1;
        ctrl.set_cv = 1'b1;
      end
      OP_JMP: take = 1'b1;
      OP_JCC: take = cond_ok;
      OP_LD: begin
        ctrl.rf_we  = 1'b1;
        ctrl.wb_sel = WB_MEM;
        ctrl.mem_rd = 1'b1;
      end
      OP_ST:   ctrl.mem_wr = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/harv_regfile.sv
module harv_regfile #(
  parameter int W    = 16,
  parameter int NREG = 16,
  parameter int AW   = 4,
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [W-1:0]    wdata,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  input  logic [PC_W-1:0] pc_val,
  output logic [W-1:0]    rd_a,
  output logic [W-1:0]    rd_b
);

  localparam int PCIDX = NREG - 1;

  logic [W-1:0] store [PCIDX];

  always_ff @(posedge clk) begin
    for (int k = 0; k < PCIDX; k++) begin
      if (we && (waddr == AW'(k))) store[k] <= wdata;
    end
  end

  always_comb begin
    rd_a = W'(pc_val);
    rd_b = W'(pc_val);
    for (int k = 0; k < PCIDX; k++) begin
      if (ra_a == AW'(k)) rd_a = store[k];
      if (ra_b == AW'(k)) rd_b = store[k];
    end
  end

  // R4: a stored value is what the next read of that entry returns
  a_r4_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != AW'(PCIDX)) |=> (ra_a != $past(waddr) || rd_a == $past(wdata)));

endmodule

// File: rtl/harv_core.sv
module harv_core
  import harv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_W    = 8,
  parameter int DADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  output logic               dmem_re,
  input  logic [DATA_W-1:0]  dmem_rdata
);

  localparam logic [REG_AW-1:0] PC_REG = REG_AW'(NREG - 1);

  phase_e              phase_q, phase_d;
  logic [PC_W-1:0]     pc_q, pc_d;
  logic [INSTR_W-1:0]  ir_q;
  flags_t              flg_q, flg_d, alu_flg;
  logic                exec, ir_en, flg_en, pc_wr, rf_we, br_take;
  ctrl_t               ctl;
  logic [OPC_W-1:0]    op_f;
  logic [REG_AW-1:0]   rd_idx, rs_idx;
  logic [7:0]          imm8;
  logic [DATA_W-1:0]   rd_val, rs_val, alu_b, alu_y, wb_data;

  assign exec   = (phase_q == PH_EXEC);
  assign op_f   = ir_q[15:12];
  assign rd_idx = ir_q[11:8];
  assign rs_idx = ir_q[7:4];
  assign imm8   = ir_q[7:0];

  harv_decode u_dec (
    .opcode (op_f),
    .cond   (rd_idx),
    .flags  (flg_q),
    .ctrl   (ctl),
    .take   (br_take)
  );

  harv_regfile #(
    .W    (DATA_W),
    .NREG (NREG),
    .AW   (REG_AW),
    .PC_W (PC_W)
  ) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (rd_idx),
    .wdata  (wb_data),
    .ra_a   (rd_idx),
    .ra_b   (rs_idx),
    .pc_val (pc_q),
    .rd_a   (rd_val),
    .rd_b   (rs_val)
  );

  assign alu_b = ctl.b_imm ? DATA_W'(imm8) : rs_val;

  harv_alu #(.W(DATA_W)) u_alu (
    .a     (rd_val),
    .b     (alu_b),
    .op    (ctl.alu_op),
    .y     (alu_y),
    .flags (alu_flg)
  );

  always_comb begin
    unique case (ctl.wb_sel)
      WB_IMM:  wb_data = DATA_W'(imm8);
      WB_MEM:  wb_data = dmem_rdata;
      default: wb_data = alu_y;
    endcase
  end

  assign pc_wr  = exec && ctl.rf_we && (rd_idx == PC_REG);
  assign rf_we  = exec && ctl.rf_we && (rd_idx != PC_REG);
  assign ir_en  = !exec;
  assign flg_en = exec && (ctl.set_nz || ctl.set_cv);

  // next-state logic
  always_comb begin
    phase_d = exec ? PH_FETCH : PH_EXEC;
    pc_d    = pc_q;
    if (!exec)        pc_d = pc_q + PC_W'(1);
    else if (br_take) pc_d = PC_W'(imm8);
    else if (pc_wr)   pc_d = wb_data[PC_W-1:0];
    flg_d = flg_q;
    if (ctl.set_nz) begin
      flg_d.n = alu_flg.n;
      flg_d.z = alu_flg.z;
    end
    if (ctl.set_cv) begin
      flg_d.c = alu_flg.c;
      flg_d.v = alu_flg.v;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      flg_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pc_q    <= pc_d;
      if (ir_en)  ir_q  <= imem_rdata;
      if (flg_en) flg_q <= flg_d;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = rs_val[DADDR_W-1:0];
  assign dmem_wdata = rd_val;
  assign dmem_we    = exec && ctl.mem_wr;
  assign dmem_re    = exec && ctl.mem_rd;

  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pc_q == '0 && !exec && flg_q == '0));

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> (exec && pc_q == $past(pc_q) + PC_W'(1)));

  a_r3_branch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && br_take) |=> (!exec && pc_q == PC_W'($past(imm8))));

  a_r4_pc_write_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && !br_take) |=> (pc_q == $past(wb_data[PC_W-1:0])));

  a_r5_data_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_we || dmem_re) |-> (exec && !(dmem_we && dmem_re)));

  a_r6_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op_f == OP_ADD) |=>
      (flg_q.z == (DATA_W'($past(rd_val) + $past(rs_val)) == '0)));

  a_r6_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op_f == OP_SUB) |=> (flg_q.c == ($past(rd_val) >= $past(rs_val))));

  a_r7_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op_f == OP_AND || op_f == OP_ORR || op_f == OP_EOR)) |=>
      (flg_q.c == $past(flg_q.c) && flg_q.v == $past(flg_q.v)));

  a_r8_cmp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op_f == OP_CMPI) |=> (flg_q.z == ($past(rd_val) == DATA_W'($past(imm8)))));

  a_r9_untaken_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op_f == OP_JCC && !br_take) |=> (pc_q == $past(pc_q)));

  a_r11_move_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op_f == OP_MOVI || op_f == OP_MOV)) |=> $stable(flg_q));

endmodule

// File: tb/test_harv_core.sv
`timescale 1ns/1ps
module test_harv_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic [7:0]  dmem_addr;
  logic [15:0] dmem_wdata;
  logic        dmem_we, dmem_re;
  logic [15:0] dmem_rdata;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 1'b0;

  always #2 clk = ~clk;

  harv_core i_harv_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: architectural state stepped per clock
  logic [7:0]  m_pc;
  logic [15:0] m_ir;
  bit          m_exec;
  logic [15:0] m_r [16];
  bit          m_n, m_z, m_c, m_v;

  initial for (int i = 0; i < 16; i++) m_r[i] = '0;

  function automatic logic [15:0] rval(input logic [3:0] idx);
    return (idx == 4'hF) ? {8'h00, m_pc} : m_r[idx];
  endfunction

  task automatic put(input logic [3:0] idx, input logic [15:0] val);
    if (idx == 4'hF) m_pc = val[7:0];
    else m_r[idx] = val;
  endtask

  task automatic model_exec();
    logic [3:0]  op, rd, rs;
    logic [7:0]  imm;
    logic [15:0] a, b, r;
    logic [16:0] wide;
    bit          t;
    op = m_ir[15:12]; rd = m_ir[11:8]; rs = m_ir[7:4]; imm = m_ir[7:0];
    a = rval(rd); b = rval(rs);
    case (op)
      4'd0: put(rd, {8'h00, imm});
      4'd1: begin
        wide = a + b; r = wide[15:0];
        m_c = wide[16]; m_v = (a[15] == b[15]) && (r[15] != a[15]);
        m_n = r[15]; m_z = (r == 0); put(rd, r);
      end
      4'd2, 4'd7: begin
        if (op == 4'd7) b = {8'h00, imm};
        r = a - b;
        m_c = (a >= b); m_v = (a[15] != b[15]) && (r[15] != a[15]);
        m_n = r[15]; m_z = (r == 0);
        if (op == 4'd2) put(rd, r);
      end
      4'd3, 4'd4, 4'd5: begin
        r = (op == 4'd3) ? (a & b) : (op == 4'd4) ? (a | b) : (a ^ b);
        m_n = r[15]; m_z = (r == 0); put(rd, r);
      end
      4'd6: put(rd, b);
      4'd8: m_pc = imm;
      4'd9: begin
        case (rd)
          4'd0: t = m_z;
          4'd1: t = m_n;
          4'd2: t = m_c;
          4'd3: t = m_v;
          default: t = 1'b0;
        endcase
        if (t) m_pc = imm;
      end
      4'd10: put(rd, dmem[b[7:0]]);
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 8'h00; m_ir = 16'h0000; m_exec = 1'b0;
      m_n = 1'b0; m_z = 1'b0; m_c = 1'b0; m_v = 1'b0;
    end else if (!m_exec) begin
      m_ir = imem[m_pc]; m_pc = m_pc + 8'd1; m_exec = 1'b1;
    end else begin
      model_exec(); m_exec = 1'b0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      bit exp_we, exp_re;
      exp_we = m_exec && (m_ir[15:12] == 4'd11);
      exp_re = m_exec && (m_ir[15:12] == 4'd10);
      check(imem_addr == m_pc, "R2 R3 R6 R9 fetch address", imem_addr, m_pc);
      check(dmem_we == exp_we && dmem_re == exp_re, "R5 data strobes",
            {dmem_we, dmem_re}, {exp_we, exp_re});
      if (exp_we || exp_re)
        check(dmem_addr == rval(m_ir[7:4]) [7:0], "R10 data address", dmem_addr, rval(m_ir[7:4]));
      if (exp_we)
        check(dmem_wdata == rval(m_ir[11:8]), "R10 R11 store data", dmem_wdata, rval(m_ir[11:8]));
    end
  end

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) imem[i] = 16'hF000;
  endtask

  task automatic load_loop_prog();
    clear_imem();
    imem[8'h00] = 16'h0001; // MOVI R0,1
    imem[8'h01] = 16'h0100; // MOVI R1,0
    imem[8'h02] = 16'h0301; // MOVI R3,1
    imem[8'h03] = 16'h710A; // CMPI R1,10
    imem[8'h04] = 16'h9008; // JZ 08
    imem[8'h05] = 16'h1130; // ADD R1,R3
    imem[8'h06] = 16'h1000; // ADD R0,R0
    imem[8'h07] = 16'h8003; // JMP 03
    imem[8'h08] = 16'h0100; // MOVI R1,0
    imem[8'h09] = 16'h0410; // MOVI R4,0x10
    imem[8'h0A] = 16'hB040; // ST R0,[R4]
    imem[8'h0B] = 16'h0411; // MOVI R4,0x11
    imem[8'h0C] = 16'hB140; // ST R1,[R4]
    imem[8'h0D] = 16'h800D; // JMP 0D
  endtask

  task automatic load_flag_prog();
    clear_imem();
    imem[8'h00] = 16'h0420; // MOVI R4,0x20
    imem[8'h01] = 16'hA040; // LD R0,[R4]   (0x7FFF)
    imem[8'h02] = 16'h0101; // MOVI R1,1
    imem[8'h03] = 16'h1010; // ADD R0,R1    -> 0x8000, N V
    imem[8'h04] = 16'h9306; // JV 06
    imem[8'h05] = 16'h05EE;
    imem[8'h06] = 16'h9108; // JN 08
    imem[8'h07] = 16'h05EE;
    imem[8'h08] = 16'h1000; // ADD R0,R0    -> 0, Z C V
    imem[8'h09] = 16'h920B; // JC 0B
    imem[8'h0A] = 16'h05DD;
    imem[8'h0B] = 16'h060F; // MOVI R6,0x0F
    imem[8'h0C] = 16'h073C; // MOVI R7,0x3C
    imem[8'h0D] = 16'h3670; // AND R6,R7    -> 0x0C, C kept
    imem[8'h0E] = 16'h9210; // JC 10
    imem[8'h10] = 16'h5770; // EOR R7,R7    -> 0, Z
    imem[8'h11] = 16'h9013; // JZ 13
    imem[8'h13] = 16'h68F0; // MOV R8,R15   -> 0x14
    imem[8'h14] = 16'h0F17; // MOVI R15,0x17 (jump)
    imem[8'h15] = 16'h09AA;
    imem[8'h17] = 16'hB840; // ST R8,[R4]
    imem[8'h18] = 16'h0421; // MOVI R4,0x21
    imem[8'h19] = 16'hB640; // ST R6,[R4]
    imem[8'h1A] = 16'h4760; // ORR R7,R6    -> 0x0C
    imem[8'h1B] = 16'h2670; // SUB R6,R7    -> 0, Z C
    imem[8'h1C] = 16'h770C; // CMPI R7,0x0C
    imem[8'h1D] = 16'h901F; // JZ 1F
    imem[8'h1E] = 16'h05EE;
    imem[8'h1F] = 16'h801F; // JMP 1F
  endtask

  task automatic run_main();
    rst_n = 1'b0;
    load_loop_prog();
    for (int i = 0; i < 256; i++) dmem[i] <= 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 8'h00, "R1 reset fetch address", imem_addr, 0);
    check(!dmem_we && !dmem_re, "R1 reset strobes", {dmem_we, dmem_re}, 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    repeat (300) @(negedge clk);
    check(dmem[8'h10] == 16'd1024, "R12 doubled register", dmem[8'h10], 1024);
    check(dmem[8'h11] == 16'd0, "R12 R8 loop counter cleared", dmem[8'h11], 0);
    check(imem_addr == 8'h0D || imem_addr == 8'h0E, "R3 halt loop", imem_addr, 8'h0D);

    rst_n = 1'b0;
    chk_en = 1'b0;
    load_flag_prog();
    dmem[8'h20] <= 16'h7FFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 8'h00, "R1 reset mid-program", imem_addr, 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    repeat (200) @(negedge clk);
    check(dmem[8'h20] == 16'h0014, "R4 R10 read of entry 15", dmem[8'h20], 16'h0014);
    check(dmem[8'h21] == 16'h000C, "R7 AND result", dmem[8'h21], 16'h000C);
    check(dmem[8'h10] == 16'd1024, "R11 unrelated data untouched", dmem[8'h10], 1024);
    check(imem_addr == 8'h1F || imem_addr == 8'h20, "R8 R9 final path", imem_addr, 8'h1F);
    chk_en = 1'b0;
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 5000, 600);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule